// File: doc/BRIEF.md
# Instruction Line Alignment Buffer

This block sits between instruction fetch and dispatch. Fetch hands over 128-bit words, each carrying four 32-bit instruction slots, and the code in them is packed tightly with no regard for where execution lines begin or end. An execution line is one to four instructions that issue together, and the top bit of each instruction says whether it closes its line. The buffer gathers the slots of each word into a slot queue, finds the line boundaries and presents one complete line at a time to dispatch, left-aligned, with a count of valid slots. A line that starts in one fetch word and finishes in the next is held back until its last slot has arrived.

Both data edges use valid/ready. On the fetch side a word moves only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` depends only on the buffer's state, never on `in_valid`. On the dispatch side a line leaves only in a cycle where `out_valid` and `out_ready` are both high. While dispatch stalls, the line on offer stays exactly as it is. Storage is twenty slots, so five lines of full length fit. After a taken branch, `flush` empties the buffer in one cycle. `flush_slot` tells the buffer at which slot the next fetched word holds the first instruction of the branch target.

Top module: `line_align_buf`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Within a fetch word, slot k is bits [32k+31:32k], and slot 0 is the oldest. Slots leave in arrival order. On `out_line`, the first instruction of a line is in bits [31:0].
- R3: Bit 31 of an instruction set to 1 marks the last instruction of its line. `out_count` is the number of slots up to and including the first marked slot, from 1 to 4.
- R4: When four slots in a row carry no end marker, the fourth slot still closes the line, and `out_count` is 4.
- R5: A line whose slots straddle two fetch words is not offered (`out_valid` stays low) until the word holding its last slot has been accepted.
- R6: `in_ready` is high exactly when at least four of the twenty slot entries are free. A word offered while `in_ready` is low is not taken and leaves no trace in the output stream.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_line` and `out_count` hold steady in the next cycle.
- R8: A cycle with `flush` high discards every buffered slot and any word offered in that same cycle. In the next cycle `out_valid` is low and `in_ready` is high.
- R9: For the first word accepted after a flush, slots below `flush_slot` are dropped. Later words are taken whole.
- R10: Slots of `out_line` at or above `out_count` read as zero.
- R11: A line is removed only in a cycle where `out_valid` and `out_ready` are both high, and the next line then follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard all buffered content this cycle |
| flush_slot | input | 2 | Slot at which the first word after a flush begins |
| in_valid | input | 1 | Fetch word valid |
| in_ready | output | 1 | Room for a full fetch word |
| in_word | input | 128 | Fetch word, four 32-bit slots |
| out_valid | output | 1 | A complete line is on offer |
| out_ready | input | 1 | Dispatch takes the line |
| out_line | output | 128 | Line slots, first instruction in bits [31:0] |
| out_count | output | 3 | Number of valid slots in the line, 1 to 4 |

## Verification
The bench splits a three-slot line across two words and checks that nothing is offered between the two words. A buffer that issued partial lines would hand dispatch half a line at that point. It fills the queue to the point where `in_ready` falls, keeps offering one more word, and then counts every line it drains. An off-by-one in the free-space test would either lose that extra word's slots or overwrite the oldest ones. Four unmarked slots must come out as a forced line of four, or the queue would deadlock. After a flush with a nonzero start slot, the bench checks that the leading slots are dropped from that one word only, and that the word offered during the flush cycle never appears.

// File: rtl/lab_pkg.sv
package lab_pkg;
  localparam int LAB_SLOT_W    = 32;
  localparam int LAB_SLOTS     = 4;
  localparam int LAB_LINE_CAP  = 5;
endpackage

// File: rtl/lab_fetch_align.sv
module lab_fetch_align #(
  parameter int SLOT_W = 32,
  parameter int SPW    = 4,
  parameter int OFF_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic [OFF_W-1:0]           flush_slot,
  input  logic                       accept,
  input  logic [SPW-1:0][SLOT_W-1:0] word,
  output logic [SPW-1:0][SLOT_W-1:0] lanes,
  output logic [CNT_W-1:0]           push_n
);
  // Slots to skip in the next accepted word (set by flush, cleared by use)
  logic [OFF_W-1:0] skip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      skip_q <= '0;
    else if (flush)  skip_q <= flush_slot;
    else if (accept) skip_q <= '0;
  end

  // Shift the word down so that the first kept slot lands in lane 0
  always_comb begin
    for (int k = 0; k < SPW; k++) begin
      if (k + int'(skip_q) < SPW) lanes[k] = word[k + int'(skip_q)];
      else                        lanes[k] = '0;
    end
  end

  assign push_n = CNT_W'(SPW) - CNT_W'(skip_q);
endmodule

// File: rtl/lab_slot_queue.sv
module lab_slot_queue #(
  parameter int SLOT_W = 32,
  parameter int SPW    = 4,
  parameter int DEPTH  = 20,
  parameter int CNT_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic [CNT_W-1:0]           push_n,
  input  logic [SPW-1:0][SLOT_W-1:0] push_data,
  input  logic [CNT_W-1:0]           pop_n,
  output logic [SPW-1:0][SLOT_W-1:0] win,
  output logic [CNT_W-1:0]           avail,
  output logic                       room
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [SLOT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [LVL_W-1:0]  level_q;

  function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] base, input int unsigned step);
    int unsigned s;
    s = int'(base) + step;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (!clear) begin
      for (int k = 0; k < SPW; k++) begin
        if (k < int'(push_n)) mem[wrap(wr_q, k)] <= push_data[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else if (clear) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else begin
      wr_q    <= wrap(wr_q, int'(push_n));
      rd_q    <= wrap(rd_q, int'(pop_n));
      level_q <= level_q + LVL_W'(push_n) - LVL_W'(pop_n);
    end
  end

  generate
    for (genvar g = 0; g < SPW; g++) begin : g_win
      assign win[g] = mem[wrap(rd_q, g)];
    end
  endgenerate

  assign avail = (level_q >= LVL_W'(SPW)) ? CNT_W'(SPW) : CNT_W'(level_q);
  assign room  = (level_q <= LVL_W'(DEPTH - SPW));
endmodule

// File: rtl/lab_line_pick.sv
module lab_line_pick #(
  parameter int SLOT_W = 32,
  parameter int SPW    = 4,
  parameter int CNT_W  = 3
) (
  input  logic [SPW-1:0][SLOT_W-1:0] win,
  input  logic [CNT_W-1:0]           avail,
  output logic                       found,
  output logic [CNT_W-1:0]           len,
  output logic [SPW-1:0][SLOT_W-1:0] line
);
  localparam int MARK = SLOT_W - 1;

  // Line length: first marked slot, or a forced stop at the last lane
  always_comb begin
    found = 1'b0;
    len   = '0;
    for (int k = 0; k < SPW; k++) begin
      if (!found && k < int'(avail) && (win[k][MARK] || k == SPW - 1)) begin
        found = 1'b1;
        len   = CNT_W'(k + 1);
      end
    end
  end

  always_comb begin
    for (int k = 0; k < SPW; k++) begin
      line[k] = (k < int'(len)) ? win[k] : '0;
    end
  end
endmodule

// File: rtl/line_align_buf.sv
module line_align_buf
  import lab_pkg::*;
#(
  parameter int SLOT_W   = LAB_SLOT_W,
  parameter int SPW      = LAB_SLOTS,
  parameter int LINE_CAP = LAB_LINE_CAP,
  localparam int WORD_W  = SLOT_W * SPW,
  localparam int OFF_W   = $clog2(SPW),
  localparam int CNT_W   = $clog2(SPW + 1),
  localparam int DEPTH   = LINE_CAP * SPW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [OFF_W-1:0]  flush_slot,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_line,
  output logic [CNT_W-1:0]  out_count
);
  logic [SPW-1:0][SLOT_W-1:0] word_slots, lanes, win, line_slots;
  logic [CNT_W-1:0]           push_raw, push_n, pop_n, avail, len;
  logic                       accept, room, found;

  assign word_slots = in_word;
  assign accept     = in_valid && in_ready && !flush;
  assign push_n     = accept ? push_raw : '0;
  assign pop_n      = (found && out_ready && !flush) ? len : '0;

  lab_fetch_align #(.SLOT_W(SLOT_W), .SPW(SPW), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_align (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_slot(flush_slot),
    .accept(accept), .word(word_slots), .lanes(lanes), .push_n(push_raw)
  );

  lab_slot_queue #(.SLOT_W(SLOT_W), .SPW(SPW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .clear(flush), .push_n(push_n), .push_data(lanes),
    .pop_n(pop_n), .win(win), .avail(avail), .room(room)
  );

  lab_line_pick #(.SLOT_W(SLOT_W), .SPW(SPW), .CNT_W(CNT_W)) u_pick (
    .win(win), .avail(avail), .found(found), .len(len), .line(line_slots)
  );

  assign in_ready  = room;
  assign out_valid = found;
  assign out_count = len;
  assign out_line  = line_slots;
endmodule

// File: rtl/line_align_buf_chk.sv
module line_align_buf_chk #(
  parameter int SLOT_W = 32,
  parameter int WORD_W = 128,
  parameter int CNT_W  = 3,
  parameter int SPW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_line,
  input logic [CNT_W-1:0]  out_count
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!out_valid && in_ready));

  p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count >= 1 && int'(out_count) <= SPW));

  p_lead_unmarked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_count >= 2) |-> !out_line[SLOT_W-1]);

  p_tail_marked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && int'(out_count) < SPW) |-> out_line[SLOT_W*int'(out_count)-1]);

  p_hold_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_line) && $stable(out_count)));

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && in_ready));

  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && int'(out_count) < SPW) |->
      ((out_line >> (SLOT_W*int'(out_count))) == '0));
endmodule

bind line_align_buf line_align_buf_chk #(
  .SLOT_W(SLOT_W), .WORD_W(WORD_W), .CNT_W(CNT_W), .SPW(SPW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line),
  .out_count(out_count)
);

// File: tb/sim_line_align_buf.sv
module sim_line_align_buf;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic [1:0]   flush_slot = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_word = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_line;
  logic [2:0]   out_count;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_align_buf u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_slot(flush_slot),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line),
    .out_count(out_count)
  );

  function automatic logic [31:0] mk(input int tag, input bit last);
    return {last, 31'(tag)};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [31:0] s0, s1, s2, s3);
    @(negedge clk);
    in_word  = {s3, s2, s1, s0};
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Check the line on offer, then take it
  task automatic take_line(input string req, input int cnt,
                           input logic [31:0] s0, s1, s2, s3);
    check({req, " valid"}, 128'(out_valid), 128'(1));
    check({req, " count"}, 128'(out_count), 128'(cnt));
    check({req, " line"}, out_line, {s3, s2, s1, s0});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 out_valid", 128'(out_valid), 128'(0));
    check("R1 in_ready", 128'(in_ready), 128'(1));
  endtask

  task automatic t_marked_lines;
    push_word(mk(1, 0), mk(2, 1), mk(3, 1), mk(4, 1));
    take_line("R2 R3 R10 two-slot", 2, mk(1, 0), mk(2, 1), 0, 0);
    take_line("R3 R11 single", 1, mk(3, 1), 0, 0, 0);
    take_line("R3 single last", 1, mk(4, 1), 0, 0, 0);
    check("R11 drained", 128'(out_valid), 128'(0));
  endtask

  task automatic t_forced_four;
    push_word(mk(10, 0), mk(11, 0), mk(12, 0), mk(13, 0));
    take_line("R4 forced four", 4, mk(10, 0), mk(11, 0), mk(12, 0), mk(13, 0));
    check("R4 drained", 128'(out_valid), 128'(0));
  endtask

  task automatic t_straddle;
    push_word(mk(20, 0), mk(21, 0), mk(22, 1), mk(23, 0));
    take_line("R5 first line", 3, mk(20, 0), mk(21, 0), mk(22, 1), 0);
    check("R5 partial line held", 128'(out_valid), 128'(0));
    push_word(mk(24, 0), mk(25, 1), mk(26, 1), mk(27, 1));
    take_line("R5 straddling line", 3, mk(23, 0), mk(24, 0), mk(25, 1), 0);
    take_line("R5 after straddle", 1, mk(26, 1), 0, 0, 0);
    take_line("R5 tail", 1, mk(27, 1), 0, 0, 0);
  endtask

  task automatic t_stall;
    push_word(mk(30, 0), mk(31, 1), mk(32, 1), mk(33, 1));
    repeat (3) begin
      @(negedge clk);
      check("R7 held line", out_line, {32'h0, 32'h0, mk(31, 1), mk(30, 0)});
      check("R11 not removed", 128'(out_count), 128'(2));
    end
    push_word(mk(34, 1), mk(35, 1), mk(36, 1), mk(37, 1));
    check("R7 held across push", out_line, {32'h0, 32'h0, mk(31, 1), mk(30, 0)});
    take_line("R11 head", 2, mk(30, 0), mk(31, 1), 0, 0);
    for (int i = 32; i < 38; i++) take_line("R11 order", 1, mk(i, 1), 0, 0, 0);
    check("R11 empty", 128'(out_valid), 128'(0));
  endtask

  task automatic t_full;
    int taken = 0;
    for (int w = 0; w < 5; w++)
      push_word(mk(100+4*w, 1), mk(101+4*w, 1), mk(102+4*w, 1), mk(103+4*w, 1));
    check("R6 ready low when full", 128'(in_ready), 128'(0));
    @(negedge clk);
    in_word  = {mk(903, 1), mk(902, 1), mk(901, 1), mk(900, 1)};
    in_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      take_line("R6 drain order", 1, mk(100 + i, 1), 0, 0, 0);
      taken++;
    end
    check("R6 extra word dropped", 128'(out_valid), 128'(0));
    check("R6 ready restored", 128'(in_ready), 128'(1));
    check("R6 lines drained", 128'(taken), 128'(20));
  endtask

  task automatic t_flush;
    push_word(mk(40, 1), mk(41, 1), mk(42, 1), mk(43, 1));
    take_line("R8 pre-flush", 1, mk(40, 1), 0, 0, 0);
    @(negedge clk);
    flush      = 1'b1;
    flush_slot = 2'd2;
    in_word    = {mk(803, 1), mk(802, 1), mk(801, 1), mk(800, 1)};
    in_valid   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flush    = 1'b0;
    in_valid = 1'b0;
    check("R8 valid low after flush", 128'(out_valid), 128'(0));
    check("R8 ready high after flush", 128'(in_ready), 128'(1));
    push_word(mk(50, 1), mk(51, 1), mk(52, 0), mk(53, 1));
    take_line("R9 offset start", 2, mk(52, 0), mk(53, 1), 0, 0);
    check("R9 skipped slots gone", 128'(out_valid), 128'(0));
    push_word(mk(60, 1), mk(61, 1), mk(62, 1), mk(63, 1));
    take_line("R9 next word whole", 1, mk(60, 1), 0, 0, 0);
    @(negedge clk);
    flush      = 1'b1;
    flush_slot = 2'd0;
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
    check("R8 flush drops pending", 128'(out_valid), 128'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_marked_lines();
    t_forced_four();
    t_straddle();
    t_stall();
    t_full();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule